// File: doc/BRIEF.md
# CAN Frame Receiver with Interframe Monitor

This block sits behind a bit-timing and destuffing stage. It takes one destuffed bus bit per strobe and follows the frame from start-of-frame to the end of the ACK field. Along the way it collects the identifier, the format flag, the remote-request flag, the length code and the payload bytes. A 15-bit CRC runs over every bit from start-of-frame to the end of the CRC sequence. When the sum is zero and the CRC delimiter is recessive, the block raises a frame-valid pulse and asks the transmit side to drive a dominant level for the ACK slot.

After the ACK delimiter the block counts the end-of-frame bits and the intermission slots that follow them. The first two intermission slots and the third slot are handled differently. A dominant bit in the first or second slot is reported as an overload condition. A dominant bit in the third slot, or at any point of bus idle, starts the next frame. After an overload the block waits for the recessive overload delimiter and then runs a fresh intermission. Generating overload frames, acceptance filtering and bit timing belong to other blocks.

Bit encoding used throughout: 0 is dominant, 1 is recessive.

Top module: `can_frame_rx`

## Requirements
- R1: With the format bit (the bit after the 12th bit following SOF) at 0, the 11 identifier bits received first (MSB first) appear in frame_id[28:18], frame_id[17:0] is 0, frame_ext is 0 and frame_rtr takes the bit that follows the identifier.
- R2: With the format bit at 1, the bit after the 11 base bits is ignored, 18 more identifier bits (MSB first) land in frame_id[17:0], the next bit is frame_rtr and frame_ext is 1.
- R3: The reserved control bits (one for standard frames, two for extended frames) are accepted with either value and do not affect frame_valid or any field.
- R4: frame_dlc holds the received 4-bit length code unchanged. frame_nbytes is min(code, MAX_BYTES) for a data frame and 0 for a remote frame. Exactly that many bytes are received, byte k in frame_data[8k+7:8k] with its first bit as the MSB, and the bytes not received read 0.
- R5: The CRC uses polynomial 0x4599, starts at 0 and covers SOF through the last CRC bit. frame_valid is high for exactly one cycle, the cycle after the CRC delimiter strobe, when that sum is 0 and the delimiter is recessive.
- R6: ack_drive rises together with frame_valid and stays high until the cycle after the next bit strobe (the ACK slot), then falls.
- R7: A CRC mismatch or a dominant CRC delimiter leaves frame_valid and ack_drive at 0 for that frame.
- R8: After the ACK delimiter, 7 end-of-frame bits are skipped and 3 intermission slots follow. A dominant bit in slot 1 or 2 gives a one-cycle overload pulse in the cycle after its strobe.
- R9: A dominant bit in intermission slot 3 is taken as SOF of the next frame, with no overload pulse.
- R10: After the third recessive intermission slot the bus is idle for any number of recessive bits, and a dominant bit is then taken as SOF.
- R11: After an overload, dominant bits neither start a frame nor pulse overload again. Eight consecutive recessive bits end the overload delimiter, and a new 3-slot intermission follows.
- R12: After reset all outputs are 0 and the block is in bus idle, so the first dominant bit is a SOF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a destuffed bit |
| rx_bit | input | 1 | Bit value, 0 dominant, 1 recessive |
| frame_valid | output | 1 | One-cycle pulse, frame received with correct CRC |
| frame_id | output | 29 | Identifier, left-aligned |
| frame_ext | output | 1 | 1 for extended format |
| frame_rtr | output | 1 | Remote request flag |
| frame_dlc | output | 4 | Received length code |
| frame_nbytes | output | $clog2(MAX_BYTES+1) | Payload bytes received |
| frame_data | output | MAX_BYTES*8 | Payload, byte 0 in the low bits |
| ack_drive | output | 1 | Request to drive dominant during the ACK slot |
| overload | output | 1 | One-cycle pulse, dominant in intermission slot 1 or 2 |

## Verification
Every result is a register loaded at the clock edge that samples the strobe. frame_valid, ack_drive, the parsed fields and overload are therefore due in the cycle right after that strobe. The ACK release is due one cycle after the ACK-slot strobe. The bench raises a strobe for one cycle, idles one cycle, and samples at the falling edge just after the strobe's rising edge. That places each result in its due cycle. An extra sample one idle cycle later confirms that frame_valid is a single-cycle pulse while ack_drive is still held. The sweep covers every length code with both formats and both RTR values. Across the sweep it varies the reserved bits, injects CRC and delimiter faults, and runs each of the four gap patterns: idle, slot-3 SOF, and overload in slot 1 or slot 2.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;

  localparam int BASE_ID_BITS = 11;
  localparam int EXT_ID_BITS  = 18;
  localparam int ID_BITS      = BASE_ID_BITS + EXT_ID_BITS;
  localparam int DLC_BITS     = 4;
  localparam int CRC_BITS     = 15;
  localparam logic [CRC_BITS-1:0] CRC_POLY = 15'h4599;

  typedef enum logic [3:0] {
    P_WAIT, P_BASE, P_B12, P_IDE, P_EXT, P_RTR, P_R1, P_R0,
    P_DLC, P_DATA, P_CRC, P_CDEL, P_ACK, P_ADEL
  } parse_st_t;

  typedef enum logic [2:0] {
    I_BUSY, I_EOF, I_INTER, I_IDLE, I_OVLD
  } ifs_st_t;

endpackage

// File: rtl/can_rx_crc15.sv
module can_rx_crc15
  import can_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic shift,
  input  logic bit_in,
  output logic crc_zero
);

  logic [CRC_BITS-1:0] crc_q;
  logic [CRC_BITS-1:0] crc_next;

  // Running the received CRC bits through the same register leaves zero on a good frame
  always_comb begin
    crc_next = {crc_q[CRC_BITS-2:0], 1'b0};
    if (bit_in ^ crc_q[CRC_BITS-1]) crc_next = crc_next ^ CRC_POLY;
  end

  always_ff @(posedge clk) begin
    if (rst)        crc_q <= '0;
    else if (clear) crc_q <= '0;
    else if (shift) crc_q <= crc_next;
  end

  assign crc_zero = (crc_q == '0);

endmodule

// File: rtl/can_rx_parser.sv
module can_rx_parser
  import can_rx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int IDX_W    = $clog2(DATA_W),
  localparam int BC_W     = $clog2(MAX_BYTES + 1),
  localparam int CNT_MAX  = (DATA_W > EXT_ID_BITS) ? DATA_W : EXT_ID_BITS,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_valid,
  input  logic                bit_val,
  input  logic                sof_hit,
  input  logic                crc_zero,
  output logic                crc_clear,
  output logic                crc_shift,
  output logic                frame_done,
  output logic                frame_valid_o,
  output logic                ack_drive_o,
  output logic [ID_BITS-1:0]  id_o,
  output logic                ide_o,
  output logic                rtr_o,
  output logic [DLC_BITS-1:0] dlc_o,
  output logic [BC_W-1:0]     nbytes_o,
  output logic [DATA_W-1:0]   data_o
);

  parse_st_t         st;
  logic [CNT_W-1:0]  cnt;
  logic [4:0]        id_pos;
  logic [IDX_W-1:0]  data_pos;
  logic [DLC_BITS-1:0] dlc_next;
  logic [BC_W-1:0]   dlc_clamp;
  logic              data_end;

  always_comb begin
    if (st == P_EXT) id_pos = 5'(EXT_ID_BITS - 1) - 5'(cnt);
    else             id_pos = 5'(ID_BITS - 1) - 5'(cnt);
  end

  // Bytes fill from the low end, first received bit of each byte is its MSB
  assign data_pos  = IDX_W'({cnt[CNT_W-1:3], ~cnt[2:0]});
  assign dlc_next  = {dlc_o[DLC_BITS-2:0], bit_val};
  assign dlc_clamp = (dlc_next > DLC_BITS'(MAX_BYTES)) ? BC_W'(MAX_BYTES) : BC_W'(dlc_next);
  assign data_end  = (cnt == CNT_W'({nbytes_o, 3'b000}) - CNT_W'(1));

  assign crc_clear  = sof_hit && (st == P_WAIT);
  assign crc_shift  = bit_valid && !(st inside {P_WAIT, P_CDEL, P_ACK, P_ADEL});
  assign frame_done = bit_valid && (st == P_ADEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= P_WAIT;
      cnt           <= '0;
      frame_valid_o <= 1'b0;
      ack_drive_o   <= 1'b0;
      id_o          <= '0;
      ide_o         <= 1'b0;
      rtr_o         <= 1'b0;
      dlc_o         <= '0;
      nbytes_o      <= '0;
      data_o        <= '0;
    end else begin
      frame_valid_o <= 1'b0;
      case (st)
        P_WAIT: if (sof_hit) begin
          st       <= P_BASE;
          cnt      <= '0;
          id_o     <= '0;
          ide_o    <= 1'b0;
          rtr_o    <= 1'b0;
          dlc_o    <= '0;
          nbytes_o <= '0;
          data_o   <= '0;
        end
        P_BASE: if (bit_valid) begin
          id_o[id_pos] <= bit_val;
          if (cnt == CNT_W'(BASE_ID_BITS - 1)) st <= P_B12;
          else cnt <= cnt + 1'b1;
        end
        P_B12: if (bit_valid) begin
          rtr_o <= bit_val;        // provisional: substitute bit on extended frames
          st    <= P_IDE;
        end
        P_IDE: if (bit_valid) begin
          ide_o <= bit_val;
          cnt   <= '0;
          st    <= bit_val ? P_EXT : P_R0;
        end
        P_EXT: if (bit_valid) begin
          id_o[id_pos] <= bit_val;
          if (cnt == CNT_W'(EXT_ID_BITS - 1)) st <= P_RTR;
          else cnt <= cnt + 1'b1;
        end
        P_RTR: if (bit_valid) begin
          rtr_o <= bit_val;
          st    <= P_R1;
        end
        P_R1: if (bit_valid) st <= P_R0;
        P_R0: if (bit_valid) begin
          cnt <= '0;
          st  <= P_DLC;
        end
        P_DLC: if (bit_valid) begin
          dlc_o <= dlc_next;
          if (cnt == CNT_W'(DLC_BITS - 1)) begin
            cnt      <= '0;
            nbytes_o <= rtr_o ? '0 : dlc_clamp;
            st       <= (rtr_o || dlc_clamp == '0) ? P_CRC : P_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_DATA: if (bit_valid) begin
          data_o[data_pos] <= bit_val;
          if (data_end) begin
            cnt <= '0;
            st  <= P_CRC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_CRC: if (bit_valid) begin
          if (cnt == CNT_W'(CRC_BITS - 1)) st <= P_CDEL;
          else cnt <= cnt + 1'b1;
        end
        P_CDEL: if (bit_valid) begin
          frame_valid_o <= bit_val && crc_zero;
          ack_drive_o   <= bit_val && crc_zero;
          st            <= P_ACK;
        end
        P_ACK: if (bit_valid) begin
          ack_drive_o <= 1'b0;
          st          <= P_ADEL;
        end
        P_ADEL: if (bit_valid) st <= P_WAIT;
        default: st <= P_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/can_rx_ifs.sv
module can_rx_ifs
  import can_rx_pkg::*;
#(
  parameter int EOF_BITS  = 7,
  parameter int IFS_BITS  = 3,
  parameter int OVL_BITS  = 8,
  localparam int CW       = $clog2(EOF_BITS + IFS_BITS + OVL_BITS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_val,
  input  logic frame_done,
  output logic sof_hit,
  output logic overload_o
);

  ifs_st_t        st;
  logic [CW-1:0]  cnt;
  logic           last_slot;

  assign last_slot = (cnt == CW'(IFS_BITS - 1));
  assign sof_hit   = bit_valid && !bit_val &&
                     ((st == I_IDLE) || (st == I_INTER && last_slot));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= I_IDLE;
      cnt        <= '0;
      overload_o <= 1'b0;
    end else begin
      overload_o <= 1'b0;
      case (st)
        I_BUSY: if (frame_done) begin
          st  <= I_EOF;
          cnt <= '0;
        end
        I_EOF: if (bit_valid) begin
          if (cnt == CW'(EOF_BITS - 1)) begin
            st  <= I_INTER;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        I_INTER: if (bit_valid) begin
          if (!bit_val) begin
            if (last_slot) begin
              st <= I_BUSY;
            end else begin
              overload_o <= 1'b1;
              st         <= I_OVLD;
              cnt        <= '0;
            end
          end else if (last_slot) begin
            st <= I_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        I_IDLE: if (sof_hit) st <= I_BUSY;
        I_OVLD: if (bit_valid) begin
          if (!bit_val) begin
            cnt <= '0;
          end else if (cnt == CW'(OVL_BITS - 1)) begin
            st  <= I_INTER;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= I_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/can_frame_rx.sv
module can_frame_rx
  import can_rx_pkg::*;
#(
  parameter int MAX_BYTES      = 8,
  parameter int EOF_BITS       = 7,
  parameter int IFS_BITS       = 3,
  parameter int OVL_DELIM_BITS = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rx_valid,
  input  logic                             rx_bit,
  output logic                             frame_valid,
  output logic [28:0]                      frame_id,
  output logic                             frame_ext,
  output logic                             frame_rtr,
  output logic [3:0]                       frame_dlc,
  output logic [$clog2(MAX_BYTES+1)-1:0]   frame_nbytes,
  output logic [MAX_BYTES*8-1:0]           frame_data,
  output logic                             ack_drive,
  output logic                             overload
);

  logic sof_hit;
  logic crc_zero;
  logic crc_clear;
  logic crc_shift;
  logic frame_done;

  can_rx_crc15 u_crc (
    .clk      (clk),
    .rst      (rst),
    .clear    (crc_clear),
    .shift    (crc_shift),
    .bit_in   (rx_bit),
    .crc_zero (crc_zero)
  );

  can_rx_parser #(.MAX_BYTES(MAX_BYTES)) u_parse (
    .clk           (clk),
    .rst           (rst),
    .bit_valid     (rx_valid),
    .bit_val       (rx_bit),
    .sof_hit       (sof_hit),
    .crc_zero      (crc_zero),
    .crc_clear     (crc_clear),
    .crc_shift     (crc_shift),
    .frame_done    (frame_done),
    .frame_valid_o (frame_valid),
    .ack_drive_o   (ack_drive),
    .id_o          (frame_id),
    .ide_o         (frame_ext),
    .rtr_o         (frame_rtr),
    .dlc_o         (frame_dlc),
    .nbytes_o      (frame_nbytes),
    .data_o        (frame_data)
  );

  can_rx_ifs #(
    .EOF_BITS (EOF_BITS),
    .IFS_BITS (IFS_BITS),
    .OVL_BITS (OVL_DELIM_BITS)
  ) u_ifs (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (rx_valid),
    .bit_val    (rx_bit),
    .frame_done (frame_done),
    .sof_hit    (sof_hit),
    .overload_o (overload)
  );

endmodule

// File: rtl/can_frame_rx_chk.sv
module can_frame_rx_chk #(
  parameter int MAX_BYTES = 8,
  localparam int BC_W     = $clog2(MAX_BYTES + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_valid,
  input logic            rx_bit,
  input logic            frame_valid,
  input logic [28:0]     frame_id,
  input logic            frame_ext,
  input logic            frame_rtr,
  input logic [3:0]      frame_dlc,
  input logic [BC_W-1:0] frame_nbytes,
  input logic            ack_drive,
  input logic            overload
);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  assert_valid_needs_recessive_delim_R7: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> $past(rx_valid && rx_bit));

  assert_ack_with_valid_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_drive) |-> frame_valid);

  assert_ack_release_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_drive && rx_valid) |=> !ack_drive);

  assert_std_id_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !frame_ext) |-> (frame_id[17:0] == 18'd0));

  assert_nbytes_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !frame_rtr && frame_dlc >= 4'(MAX_BYTES)) |-> (frame_nbytes == BC_W'(MAX_BYTES)));

  assert_remote_no_bytes_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && frame_rtr) |-> (frame_nbytes == '0));

  assert_overload_on_dominant_R8: assert property (@(posedge clk) disable iff (rst)
    overload |-> $past(rx_valid && !rx_bit));

  assert_overload_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(overload && (frame_valid || ack_drive)));

endmodule

bind can_frame_rx can_frame_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_valid     (rx_valid),
  .rx_bit       (rx_bit),
  .frame_valid  (frame_valid),
  .frame_id     (frame_id),
  .frame_ext    (frame_ext),
  .frame_rtr    (frame_rtr),
  .frame_dlc    (frame_dlc),
  .frame_nbytes (frame_nbytes),
  .ack_drive    (ack_drive),
  .overload     (overload)
);

// File: tb/can_frame_rx_test.sv
`timescale 1ns/1ps
module can_frame_rx_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic        rx_bit = 1'b1;
  logic        frame_valid;
  logic [28:0] frame_id;
  logic        frame_ext;
  logic        frame_rtr;
  logic [3:0]  frame_dlc;
  logic [3:0]  frame_nbytes;
  logic [63:0] frame_data;
  logic        ack_drive;
  logic        overload;

  int checks = 0;
  int fails  = 0;
  logic bits [0:255];
  int nbits;

  always #2 clk = ~clk;

  can_frame_rx uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .frame_valid(frame_valid), .frame_id(frame_id), .frame_ext(frame_ext),
    .frame_rtr(frame_rtr), .frame_dlc(frame_dlc), .frame_nbytes(frame_nbytes),
    .frame_data(frame_data), .ack_drive(ack_drive), .overload(overload)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // One strobe cycle, then return at the falling edge right after the sampling edge
  task automatic drive_bit(input logic b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_bit   = b;
    @(negedge clk);
    rx_valid = 1'b0;
    rx_bit   = 1'b1;
  endtask

  task automatic push(input logic b);
    bits[nbits] = b;
    nbits++;
  endtask

  function automatic logic [14:0] crc_step(input logic [14:0] c, input logic b);
    logic [14:0] n;
    n = {c[13:0], 1'b0};
    if (b ^ c[14]) n = n ^ 15'h4599;
    return n;
  endfunction

  task automatic send_frame(input string ctx, input logic ext, input logic [28:0] id,
                            input logic rtr, input logic [3:0] dlc, input logic r1,
                            input logic r0, input int fault, input logic [63:0] data);
    int nb;
    logic [14:0] crc;
    logic [63:0] exp_data;
    logic [28:0] exp_id;
    logic ok;
    nb = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
    nbits = 0;
    push(1'b0);
    for (int j = 10; j >= 0; j--) push(id[18+j]);
    if (!ext) begin
      push(rtr); push(1'b0); push(r0);
    end else begin
      push(1'b1); push(1'b1);
      for (int j = 17; j >= 0; j--) push(id[j]);
      push(rtr); push(r1); push(r0);
    end
    for (int j = 3; j >= 0; j--) push(dlc[j]);
    exp_data = '0;
    for (int b = 0; b < nb; b++) begin
      for (int j = 7; j >= 0; j--) push(data[8*b+j]);
      exp_data[8*b +: 8] = data[8*b +: 8];
    end
    crc = '0;
    for (int j = 0; j < nbits; j++) crc = crc_step(crc, bits[j]);
    for (int j = 14; j >= 0; j--) push(crc[j]);
    if (fault == 1) bits[nbits-1] = ~bits[nbits-1];
    for (int j = 0; j < nbits; j++) drive_bit(bits[j]);
    drive_bit(fault == 2 ? 1'b0 : 1'b1);
    ok = (fault == 0);
    exp_id = ext ? id : {id[28:18], 18'd0};
    check($sformatf("%s R3/R5/R7 frame_valid after delimiter", ctx), 64'(frame_valid), 64'(ok));
    check($sformatf("%s R6/R7 ack_drive after delimiter", ctx), 64'(ack_drive), 64'(ok));
    if (ok) begin
      check($sformatf("%s R1/R2 frame_id", ctx), 64'(frame_id), 64'(exp_id));
      check($sformatf("%s R1/R2 frame_ext", ctx), 64'(frame_ext), 64'(ext));
      check($sformatf("%s R1/R2 frame_rtr", ctx), 64'(frame_rtr), 64'(rtr));
      check($sformatf("%s R4 frame_dlc", ctx), 64'(frame_dlc), 64'(dlc));
      check($sformatf("%s R4 frame_nbytes", ctx), 64'(frame_nbytes), 64'(nb));
      check($sformatf("%s R4 frame_data", ctx), frame_data, exp_data);
    end
    @(negedge clk);
    check($sformatf("%s R5 frame_valid single cycle", ctx), 64'(frame_valid), 64'd0);
    check($sformatf("%s R6 ack_drive held before slot", ctx), 64'(ack_drive), 64'(ok));
    drive_bit(1'b0);
    check($sformatf("%s R6 ack_drive released after slot", ctx), 64'(ack_drive), 64'd0);
    drive_bit(1'b1);
    for (int j = 0; j < 7; j++) begin
      drive_bit(1'b1);
      check($sformatf("%s R8 no overload in EOF", ctx), 64'(overload), 64'd0);
    end
  endtask

  // mode 0: idle gap, 1: SOF in slot 3, 2/3: overload in slot 1/2
  task automatic gap(input int mode, input int idle_len);
    if (mode == 0) begin
      for (int j = 0; j < 3 + idle_len; j++) begin
        drive_bit(1'b1);
        check("R10 no overload on recessive gap", 64'(overload), 64'd0);
      end
    end else if (mode == 1) begin
      for (int j = 0; j < 2; j++) begin
        drive_bit(1'b1);
        check("R9 no overload before slot 3", 64'(overload), 64'd0);
      end
    end else begin
      for (int j = 0; j < mode - 2; j++) drive_bit(1'b1);
      drive_bit(1'b0);
      check($sformatf("R8 overload pulse in slot %0d", mode - 1), 64'(overload), 64'd1);
      @(negedge clk);
      check("R8 overload single cycle", 64'(overload), 64'd0);
      for (int j = 0; j < 5; j++) begin
        drive_bit(1'b0);
        check("R11 no overload during flag", 64'(overload), 64'd0);
      end
      for (int j = 0; j < 8; j++) drive_bit(1'b1);
      for (int j = 0; j < 3; j++) begin
        drive_bit(1'b1);
        check("R11 no overload in fresh intermission", 64'(overload), 64'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    string ctx;
    int prev_mode;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 reset frame_valid", 64'(frame_valid), 64'd0);
    check("R12 reset ack_drive", 64'(ack_drive), 64'd0);
    check("R12 reset overload", 64'(overload), 64'd0);
    check("R12 reset frame_id", 64'(frame_id), 64'd0);
    check("R12 reset frame_nbytes", 64'(frame_nbytes), 64'd0);
    prev_mode = -1;
    for (int i = 0; i < 64; i++) begin
      logic ext;
      logic rtr;
      logic [3:0] dlc;
      logic [28:0] id;
      logic [63:0] data;
      int fault;
      ext = i[0];
      rtr = i[1];
      dlc = 4'(i >> 2);
      id  = ext ? 29'(i * 123457 + 77) : {11'(i * 37 + 5), 18'd0};
      for (int k = 0; k < 8; k++) data[8*k +: 8] = 8'(i * 17 + k * 29 + 3);
      fault = (i % 7 == 3) ? 1 : ((i % 11 == 5) ? 2 : 0);
      case (prev_mode)
        -1: ctx = "R12 first";
        0: ctx = "R10 after idle";
        1: ctx = "R9 slot3 SOF";
        default: ctx = "R11 after overload";
      endcase
      send_frame(ctx, ext, id, rtr, dlc, 1'(i % 3 == 0), 1'((i % 5) < 2), fault, data);
      prev_mode = i % 4;
      gap(prev_mode, 1 + i % 3);
    end
    summary();
    $finish;
  end

endmodule